// File: doc/BRIEF.md
# Cascadable Dual Timer / Event Counter

The block holds two 8-bit up-counters, timer A and timer B, each with its own compare (modulo) register. A free-running 8-bit prescaler in the system clock domain supplies one-cycle enable pulses at divide ratios of 4, 16, 64 and 256. Each timer counts on either a prescaler tap (timer mode) or on rising edges of its external event pin (event mode). Event mode is chosen by a bit in the pin-select register. Timer B can also be clocked by timer A's match pulse. In that setting the pair forms one 16-bit timer, and `match_b` marks the 16-bit period.

Software works through a small register port. Writes take effect on the clock edge, and reads are combinational. Writing a data register changes only the compare value. Reading it returns the live count. When the count equals a nonzero compare value on a counting tick, the counter returns to zero and the timer's match output pulses for one cycle.

Each timer runs a two-state controller, `CH_HOLD` and `CH_COUNT`:
- The transition *go* (HOLD to COUNT) happens on a mode write with the start bit or the continue bit set.
- The transition *stop* (COUNT to HOLD) happens on a mode write with both bits clear.
- The action *restart* happens on any mode write with the start bit set. It clears the count in either state and enters COUNT.

Top module: `dual_evt_timer`

## Requirements
- R1: After reset, all four registers read 0 and both match outputs are low. The registers are mode at address 0, data A at 1, data B at 2 and pin-select at 3. Both counts are 0 and both timers are in HOLD.
- R2: Mode register bits are as follows. Bits [1:0] select A's tap: 00 gives /4, 01 gives /16, 10 gives /64 and 11 gives /256. Bit 2 is the A continue bit and bit 3 is the A start bit. Bits [5:4] select B's source and bit 6 is the B start bit. Bit 7 reads 0. A tick of /2^k fires in the cycle where the low k bits of the prescaler, which counts from 0 after reset, are all ones.
- R3: A write to address 1 or 2 sets that timer's compare value and leaves its count unchanged. A read of address 1 or 2 returns the current count.
- R4: On a counting tick with a nonzero compare value equal to the count, the count becomes 0. The match output is high for exactly the following cycle.
- R5: With a compare value of 0, no match occurs, and the counter wraps from 255 to 0.
- R6: Writing a start bit of 1 clears that count and starts counting. Writing mode with timer A's start and continue bits both 0, or with timer B's start bit 0, holds that count unchanged.
- R7: Writing timer A's continue bit as 1 with its start bit 0 resumes counting from the held value without clearing it.
- R8: B source code 00 counts one step per timer A match pulse, one cycle after that pulse. Codes 01, 10 and 11 select the /4, /16 and /64 taps.
- R9: Pin-select bit 0 (for A) or bit 1 (for B) set to 1 makes that timer count rising edges of its event pin. The event pin passes through a two-flop synchronizer and an edge detector, so the count moves on the third clock edge after the pin rises.
- R10: With its pin-select bit 0, a timer ignores its event pin and counts its selected internal source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| evt_in | input | 2 | External event pins, bit 0 for A, bit 1 for B |
| match_a | output | 1 | One-cycle match pulse of timer A |
| match_b | output | 1 | One-cycle match pulse of timer B (16-bit match in cascade) |

## Verification
The reference model runs timer A on each of the four taps with a zero compare value. This separates the divide ratios from each other and exposes the wrap at 255. Runs with a small nonzero compare value show the clear-on-match timing and the pulse width. A compare write made while the timer runs tells a modulo update apart from a count update.

The cascade run uses small compare values on both timers, so `match_b` marks the 16-bit period. Event-pin runs with each pin-select setting separate edge counting from the pin being ignored. Hold, restart and continue writes made mid-count show whether the count is kept or cleared.

// File: rtl/det_pkg.sv
`timescale 1ns/1ps
package det_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int TAP_N   = 4;
    localparam int PIN_N   = 2;
    localparam int MODE_W  = 7;

    typedef enum logic {
        CH_HOLD  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_e;

    localparam logic [ADDR_W-1:0] ADDR_MODE   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DATA_A = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DATA_B = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_PINSEL = 2'd3;
endpackage

// File: rtl/det_prescaler.sv
`timescale 1ns/1ps
module det_prescaler #(
    parameter int TAPS = det_pkg::TAP_N
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] tap_tick
);
    localparam int PS_W = 2 * TAPS;

    logic [PS_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // tap i divides by 2^(2*(i+1))
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        localparam int LOW = 2 * (i + 1);
        assign tap_tick[i] = &div_q[LOW-1:0];
    end
endmodule

// File: rtl/det_evt_sync.sv
`timescale 1ns/1ps
module det_evt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/det_channel.sv
`timescale 1ns/1ps
module det_channel
    import det_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ctl_we,
    input  logic         ctl_start,
    input  logic         ctl_cont,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cmp,
    output logic         match,
    output logic         running
);
    ch_state_e    state_q, state_d;
    logic [W-1:0] cnt_q, cmp_q;
    logic         match_q;
    logic         step, hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_HOLD;
        else        state_q <= state_d;
    end

    // transitions: go / stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HOLD:  if (ctl_we && (ctl_start || ctl_cont))   state_d = CH_COUNT;
            CH_COUNT: if (ctl_we && !ctl_start && !ctl_cont)   state_d = CH_HOLD;
            default:  state_d = CH_HOLD;
        endcase
    end

    assign step = (state_q == CH_COUNT) && tick;
    assign hit  = step && (cmp_q != '0) && (cnt_q == cmp_q);

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cmp_q   <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= hit;
            if (cmp_we) cmp_q <= cmp_wdata;
            if (ctl_we && ctl_start) cnt_q <= '0;
            else if (hit)            cnt_q <= '0;
            else if (step)           cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign cmp     = cmp_q;
    assign match   = match_q;
    assign running = (state_q == CH_COUNT);
endmodule

// File: rtl/dual_evt_timer.sv
`timescale 1ns/1ps
module dual_evt_timer
    import det_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_N-1:0]  evt_in,
    output logic              match_a,
    output logic              match_b
);
    localparam int CH_N = 2;

    logic [MODE_W-1:0] mode_q;
    logic [PIN_N-1:0]  pin_q;
    logic [TAP_N-1:0]  taps;
    logic [PIN_N-1:0]  evt_rise;
    logic              mode_we;

    logic [CH_N-1:0]   tick_v, start_v, cont_v, cmp_we_v, match_v, run_v;
    logic [DATA_W-1:0] cnt_v [CH_N];
    logic [DATA_W-1:0] cmp_v [CH_N];

    logic [DATA_W-1:0] cnt_a, cnt_b, cmp_a, cmp_b;
    logic              run_a, run_b;
    logic              tap_a, src_b;

    assign mode_we = bus_we && (bus_addr == ADDR_MODE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            pin_q  <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_MODE)   mode_q <= bus_wdata[MODE_W-1:0];
            if (bus_addr == ADDR_PINSEL) pin_q  <= bus_wdata[PIN_N-1:0];
        end
    end

    det_prescaler #(.TAPS(TAP_N)) u_ps (
        .clk(clk), .rst_n(rst_n), .tap_tick(taps)
    );

    for (genvar p = 0; p < PIN_N; p++) begin : g_sync
        det_evt_sync u_sync (
            .clk(clk), .rst_n(rst_n), .pin(evt_in[p]), .rise(evt_rise[p])
        );
    end

    // clock source selection
    always_comb begin
        tap_a = taps[mode_q[1:0]];
        unique case (mode_q[5:4])
            2'b00:   src_b = match_v[0];
            2'b01:   src_b = taps[0];
            2'b10:   src_b = taps[1];
            default: src_b = taps[2];
        endcase
        tick_v[0] = pin_q[0] ? evt_rise[0] : tap_a;
        tick_v[1] = pin_q[1] ? evt_rise[1] : src_b;
    end

    assign start_v  = {bus_wdata[6], bus_wdata[3]};
    assign cont_v   = {1'b0,         bus_wdata[2]};
    assign cmp_we_v = {bus_we && (bus_addr == ADDR_DATA_B),
                       bus_we && (bus_addr == ADDR_DATA_A)};

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        det_channel #(.W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick_v[c]),
            .ctl_we(mode_we), .ctl_start(start_v[c]), .ctl_cont(cont_v[c]),
            .cmp_we(cmp_we_v[c]), .cmp_wdata(bus_wdata),
            .cnt(cnt_v[c]), .cmp(cmp_v[c]), .match(match_v[c]), .running(run_v[c])
        );
    end

    assign cnt_a = cnt_v[0];
    assign cnt_b = cnt_v[1];
    assign cmp_a = cmp_v[0];
    assign cmp_b = cmp_v[1];
    assign run_a = run_v[0];
    assign run_b = run_v[1];
    assign match_a = match_v[0];
    assign match_b = match_v[1];

    always_comb begin
        unique case (bus_addr)
            ADDR_MODE:   bus_rdata = {{(DATA_W-MODE_W){1'b0}}, mode_q};
            ADDR_DATA_A: bus_rdata = cnt_a;
            ADDR_DATA_B: bus_rdata = cnt_b;
            default:     bus_rdata = {{(DATA_W-PIN_N){1'b0}}, pin_q};
        endcase
    end
endmodule

// File: rtl/det_checker.sv
`timescale 1ns/1ps
module det_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       match_a,
    input logic       match_b,
    input logic [7:0] cnt_a,
    input logic [7:0] cnt_b,
    input logic [7:0] cmp_a,
    input logic [7:0] cmp_b,
    input logic       run_a,
    input logic       run_b,
    input logic       mode_we
);
    // R4
    match_a_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_a |=> !match_a);
    // R4
    match_b_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_b |=> !match_b);
    // R4
    match_a_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_a |-> (cnt_a == 8'd0));
    // R5
    cmp_a_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmp_a) == 8'd0) |-> !match_a);
    // R5
    cmp_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmp_b) == 8'd0) |-> !match_b);
    // R6
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_a && !mode_we) |=> $stable(cnt_a));
    // R6
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_b && !mode_we) |=> $stable(cnt_b));
endmodule

bind dual_evt_timer det_checker u_chk (
    .clk(clk), .rst_n(rst_n), .match_a(match_a), .match_b(match_b),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .run_a(run_a), .run_b(run_b), .mode_we(mode_we)
);

// File: tb/sim_dual_evt_timer.sv
`timescale 1ns/1ps
module sim_dual_evt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [1:0] evt_in = 2'b00;
    logic       match_a, match_b;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    logic [1:0] watch = 2'd1;

    always #2.5 clk = ~clk;

    dual_evt_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .match_a(match_a), .match_b(match_b)
    );

    // behavioural reference model
    int m_pre, m_ca, m_cb, m_cmpa, m_cmpb, m_mode, m_pin;
    bit m_runa, m_runb, m_ma, m_mb;
    bit m_s1 [2], m_s2 [2], m_s3 [2];

    function automatic bit tap(int pre, int div);
        return (pre % div) == (div - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_ca = 0; m_cb = 0; m_cmpa = 0; m_cmpb = 0;
            m_mode = 0; m_pin = 0; m_runa = 0; m_runb = 0; m_ma = 0; m_mb = 0;
            for (int i = 0; i < 2; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; end
        end else begin
            bit ea, eb, ena, enb, nma, nmb;
            int divs [4];
            divs = '{4, 16, 64, 256};
            ea = m_s2[0] && !m_s3[0];
            eb = m_s2[1] && !m_s3[1];
            for (int i = 0; i < 2; i++) begin
                m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = evt_in[i];
            end
            ena = m_pin[0] ? ea : tap(m_pre, divs[m_mode & 3]);
            if (m_pin[1]) enb = eb;
            else if (((m_mode >> 4) & 3) == 0) enb = m_ma;
            else enb = tap(m_pre, divs[((m_mode >> 4) & 3) - 1]);
            nma = 0; nmb = 0;
            if (m_runa && ena) begin
                if (m_cmpa != 0 && m_ca == m_cmpa) begin m_ca = 0; nma = 1; end
                else m_ca = (m_ca + 1) % 256;
            end
            if (m_runb && enb) begin
                if (m_cmpb != 0 && m_cb == m_cmpb) begin m_cb = 0; nmb = 1; end
                else m_cb = (m_cb + 1) % 256;
            end
            if (bus_we) begin
                case (bus_addr)
                    2'd0: begin
                        m_mode = bus_wdata & 8'h7f;
                        if (bus_wdata[3]) begin m_ca = 0; m_runa = 1; end
                        else m_runa = bus_wdata[2];
                        if (bus_wdata[6]) begin m_cb = 0; m_runb = 1; end
                        else m_runb = 0;
                    end
                    2'd1: m_cmpa = bus_wdata;
                    2'd2: m_cmpb = bus_wdata;
                    default: m_pin = bus_wdata & 3;
                endcase
            end
            m_ma = nma; m_mb = nmb;
            m_pre = (m_pre + 1) % 256;
        end
    end

    function automatic int exp_rdata(logic [1:0] a);
        case (a)
            2'd0: return m_mode;
            2'd1: return m_ca;
            2'd2: return m_cb;
            default: return m_pin;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compared on every clock, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk(cur_req, bus_rdata, exp_rdata(bus_addr));
            chk("R4", match_a, m_ma);
            chk("R4", match_b, m_mb);
        end
    end

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = watch;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic look(logic [1:0] a);
        @(negedge clk);
        watch = a; bus_addr = a;
    endtask

    task automatic pulses(int idx, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); evt_in[idx] = 1'b1;
            idle(3);
            evt_in[idx] = 1'b0;
            idle(2);
        end
    endtask

    initial begin
        int held;
        idle(4);
        rst_n = 1'b1;
        // R1: reset state, register map
        for (int a = 0; a < 4; a++) begin
            look(a[1:0]);
            #1 chk("R1", bus_rdata, 0);
        end
        chk("R1", match_a, 0);
        chk("R1", match_b, 0);
        look(2'd1);

        // R2 taps of timer A, compare 0 (R5 wrap)
        cur_req = "R2";
        for (int s = 0; s < 4; s++) begin
            wr(2'd0, 8'h08 | s[7:0]);
            idle(s == 3 ? 700 : 300);
        end
        cur_req = "R5";
        wr(2'd0, 8'h08);
        idle(1100);

        // R4 compare-clear
        cur_req = "R4";
        wr(2'd1, 8'd5);
        wr(2'd0, 8'h08);
        idle(200);
        // R3 compare write does not touch count
        cur_req = "R3";
        wr(2'd1, 8'd9);
        idle(150);

        // R6 hold and restart
        cur_req = "R6";
        wr(2'd0, 8'h00);
        @(negedge clk); #1 held = bus_rdata;
        idle(100);
        #1 chk("R6", bus_rdata, held);
        wr(2'd0, 8'h08);
        idle(60);

        // R7 continue without clear
        cur_req = "R7";
        wr(2'd0, 8'h00);
        idle(20);
        wr(2'd0, 8'h04);
        idle(100);

        // R8 cascade, then B taps
        cur_req = "R8";
        look(2'd2);
        wr(2'd1, 8'd2);
        wr(2'd2, 8'd3);
        wr(2'd0, 8'h48);
        idle(500);
        wr(2'd2, 8'd0);
        for (int s = 1; s < 4; s++) begin
            wr(2'd0, 8'h40 | (s[7:0] << 4));
            idle(300);
        end

        // R9 event mode on both pins
        cur_req = "R9";
        wr(2'd3, 8'h03);
        wr(2'd1, 8'd4);
        wr(2'd0, 8'h48);
        look(2'd1);
        pulses(0, 11);
        look(2'd2);
        pulses(1, 7);
        idle(5);

        // R10 pins ignored when not selected
        cur_req = "R10";
        wr(2'd3, 8'h00);
        wr(2'd1, 8'd0);
        wr(2'd0, 8'h4B);
        pulses(1, 10);
        #1 chk("R10", bus_rdata, 0);
        look(2'd1);
        pulses(0, 10);
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule